// File: doc/BRIEF.md
# Serial-Input Latched Output Driver

This block models the logic of a cascadable display driver in synchronous form. A chain of register stages loads one bit at a time from an external shift clock. A bank of per-bit latches copies the chain into a parallel output word under a strobe, and a blanking control turns every output off. The last stage is brought out as a serial output, so several of these blocks can be chained into one long shift path. All four external controls (serial data, shift clock, strobe and blanking) are slow signals. A fast system clock samples them through two-flop synchronizers.

The latches are level-sensitive. While the strobe is high they follow the chain, and while it is low they keep what they hold. Blanking acts only on the output gating and never on the latch contents. When the strobe is tied high, the latches are bypassed and blanking must stay high during serial entry to hide the moving data.

A timing monitor counts system-clock cycles between edges of the synchronized controls and checks them against parameterized minimums. These cover data setup before a clock rise, data hold after it, clock and data pulse widths, strobe pulse width, and the gap from a clock rise to a strobe rise. Any breach sets a sticky flag, and a clear input removes it.

Top module: `latchedSerialDriver`

## Requirements
- R1: While rstN is low at a system-clock edge, the chain, the latches and the violation flag are cleared, so parOut, serOut and timingViol read 0.
- R2: On each detected low-to-high transition of shiftClk, the serial data bit is captured into stage 1, which is shown on parOut[0] when the latches are transparent and blanking is low.
- R3: Each shift moves every stage one place toward serOut: stage k takes the old stage k-1. After N shifts with the bits sent most significant first, a strobe makes parOut equal the sent word (parOut[i] is stage i+1).
- R4: serOut shows stage N. After j shifts of a new word (1 <= j < N), serOut equals bit N-1-j of the previously loaded word, and after N shifts it equals bit N-1 of the new word.
- R5: While strobeIn is low, the latches hold, and parOut does not change during shifting.
- R6: While strobeIn is high, the latches follow the chain, so with blanking low parOut tracks every shift.
- R7: While blankIn is high, parOut is all zero whatever the latches hold.
- R8: Blanking does not alter the latches. When blankIn returns low, parOut again equals the word held before blanking.
- R9: A shift-clock rise that comes fewer than SETUP_CYC cycles after a data change, or a data change fewer than HOLD_CYC cycles after a clock rise, sets timingViol.
- R10: A clock level lasting fewer than CLK_PW_CYC cycles, a data level lasting fewer than DATA_PW_CYC cycles, or a strobe high pulse shorter than STB_PW_CYC cycles sets timingViol.
- R11: A strobe rise fewer than CLK_TO_STB_CYC cycles after a shift-clock rise sets timingViol.
- R12: timingViol stays set until violClear is asserted for a cycle, which clears it.
- R13: Stimulus that meets every spacing rule never sets timingViol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serIn | input | 1 | Serial data into stage 1 |
| shiftClk | input | 1 | External shift clock, rising edge shifts |
| strobeIn | input | 1 | Latch enable, transparent while high |
| blankIn | input | 1 | Forces all outputs off while high |
| violClear | input | 1 | Clears the sticky timing flag |
| parOut | output | N | Gated parallel output word, bit i is stage i+1 |
| serOut | output | 1 | Last stage, for cascading |
| timingViol | output | 1 | Sticky timing-rule violation flag |

## Verification
The assertions take the controls as already synchronized. They relate the shift and latch enables to the next state of the chain and latches, and they take for granted that every control is held for at least a few system cycles, so that the synchronizers pass no glitch. The stimulus changes each control only after waits of tens of cycles. It places data changes in the middle of the clock low phase and keeps strobes well away from clock rises. The only exceptions are the rule-breaking cases, which are grouped at the end and followed by a clear pulse.

// File: rtl/latchedSerialDriverPkg.sv
package latchedSerialDriverPkg;

  typedef struct packed {
    logic shiftEn;
    logic dataBit;
    logic latchEn;
    logic blankOn;
  } ctlStrobes_t;

endpackage

// File: rtl/sldSync.sv
module sldSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= pipe[s-1];
      end
    end
  end

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/sldControl.sv
module sldControl
  import latchedSerialDriverPkg::*;
#(
  parameter int SETUP_CYC      = 8,
  parameter int HOLD_CYC       = 8,
  parameter int CLK_PW_CYC     = 15,
  parameter int DATA_PW_CYC    = 15,
  parameter int STB_PW_CYC     = 10,
  parameter int CLK_TO_STB_CYC = 30
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        violClear,
  input  logic        synData,
  input  logic        synClk,
  input  logic        synStrobe,
  input  logic        synBlank,
  output ctlStrobes_t ctl,
  output logic        violPulse,
  output logic        timingViol
);

  localparam int CW = $clog2(SETUP_CYC + HOLD_CYC + CLK_PW_CYC + DATA_PW_CYC
                             + STB_PW_CYC + CLK_TO_STB_CYC + 2) + 1;
  localparam int NEVT = 4;
  localparam int EV_DATA = 0;
  localparam int EV_RISE = 1;
  localparam int EV_CEDGE = 2;
  localparam int EV_STB = 3;

  localparam logic [CW-1:0] LIM_SETUP = CW'(SETUP_CYC);
  localparam logic [CW-1:0] LIM_HOLD  = CW'(HOLD_CYC);
  localparam logic [CW-1:0] LIM_CPW   = CW'(CLK_PW_CYC);
  localparam logic [CW-1:0] LIM_DPW   = CW'(DATA_PW_CYC);
  localparam logic [CW-1:0] LIM_SPW   = CW'(STB_PW_CYC);
  localparam logic [CW-1:0] LIM_C2S   = CW'(CLK_TO_STB_CYC);

  logic prevData, prevClk, prevStb;
  logic clkRise, clkFall, dataChg, stbRise, stbFall;
  logic [NEVT-1:0] evt;
  logic [CW-1:0] since [NEVT];
  logic [5:0] ruleBad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevData <= 1'b0;
      prevClk  <= 1'b0;
      prevStb  <= 1'b0;
    end else begin
      prevData <= synData;
      prevClk  <= synClk;
      prevStb  <= synStrobe;
    end
  end

  assign clkRise = synClk & ~prevClk;
  assign clkFall = ~synClk & prevClk;
  assign dataChg = synData ^ prevData;
  assign stbRise = synStrobe & ~prevStb;
  assign stbFall = ~synStrobe & prevStb;

  assign evt[EV_DATA]  = dataChg;
  assign evt[EV_RISE]  = clkRise;
  assign evt[EV_CEDGE] = clkRise | clkFall;
  assign evt[EV_STB]   = stbRise;

  // Each counter holds the number of cycles since its event, saturating.
  for (genvar g = 0; g < NEVT; g++) begin : g_since
    always_ff @(posedge clk) begin
      if (!rstN)                since[g] <= '1;
      else if (evt[g])          since[g] <= CW'(1);
      else if (since[g] != '1)  since[g] <= since[g] + CW'(1);
    end
  end

  assign ruleBad[0] = clkRise && (since[EV_DATA] < LIM_SETUP);
  assign ruleBad[1] = dataChg && (since[EV_RISE] < LIM_HOLD);
  assign ruleBad[2] = dataChg && (since[EV_DATA] < LIM_DPW);
  assign ruleBad[3] = (clkRise | clkFall) && (since[EV_CEDGE] < LIM_CPW);
  assign ruleBad[4] = stbFall && (since[EV_STB] < LIM_SPW);
  assign ruleBad[5] = stbRise && (since[EV_RISE] < LIM_C2S);

  assign violPulse = |ruleBad;

  always_ff @(posedge clk) begin
    if (!rstN)          timingViol <= 1'b0;
    else if (violPulse) timingViol <= 1'b1;
    else if (violClear) timingViol <= 1'b0;
  end

  always_comb begin
    ctl.shiftEn = clkRise;
    ctl.dataBit = synData;
    ctl.latchEn = synStrobe;
    ctl.blankOn = synBlank;
  end

endmodule

// File: rtl/sldDatapath.sv
module sldDatapath
  import latchedSerialDriverPkg::*;
#(
  parameter int N = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  output logic [N-1:0] shiftWord,
  output logic [N-1:0] latchWord,
  output logic [N-1:0] parOut,
  output logic         serOut
);

  always_ff @(posedge clk) begin
    if (!rstN)            shiftWord <= '0;
    else if (ctl.shiftEn) shiftWord <= {shiftWord[N-2:0], ctl.dataBit};
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)            latchWord[i] <= 1'b0;
      else if (ctl.latchEn) latchWord[i] <= shiftWord[i];
    end
    assign parOut[i] = latchWord[i] & ~ctl.blankOn;
  end

  assign serOut = shiftWord[N-1];

endmodule

// File: rtl/latchedSerialDriver.sv
module latchedSerialDriver
  import latchedSerialDriverPkg::*;
#(
  parameter int N              = 20,
  parameter int SYNC_STAGES    = 2,
  parameter int SETUP_CYC      = 8,
  parameter int HOLD_CYC       = 8,
  parameter int CLK_PW_CYC     = 15,
  parameter int DATA_PW_CYC    = 15,
  parameter int STB_PW_CYC     = 10,
  parameter int CLK_TO_STB_CYC = 30
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serIn,
  input  logic         shiftClk,
  input  logic         strobeIn,
  input  logic         blankIn,
  input  logic         violClear,
  output logic [N-1:0] parOut,
  output logic         serOut,
  output logic         timingViol
);

  localparam int LANES = 4;

  logic [LANES-1:0] rawIn, synIn;
  ctlStrobes_t ctl;
  logic violPulse;
  logic [N-1:0] shiftWord, latchWord;

  assign rawIn = {blankIn, strobeIn, shiftClk, serIn};

  sldSync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(synIn)
  );

  sldControl #(
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .CLK_PW_CYC(CLK_PW_CYC),
    .DATA_PW_CYC(DATA_PW_CYC), .STB_PW_CYC(STB_PW_CYC),
    .CLK_TO_STB_CYC(CLK_TO_STB_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .violClear(violClear),
    .synData(synIn[0]), .synClk(synIn[1]), .synStrobe(synIn[2]),
    .synBlank(synIn[3]), .ctl(ctl), .violPulse(violPulse),
    .timingViol(timingViol)
  );

  sldDatapath #(.N(N)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shiftWord(shiftWord),
    .latchWord(latchWord), .parOut(parOut), .serOut(serOut)
  );

endmodule

// File: rtl/sldChecker.sv
module sldChecker
  import latchedSerialDriverPkg::*;
#(
  parameter int N = 20
) (
  input logic         clk,
  input logic         rstN,
  input logic         violClear,
  input ctlStrobes_t  ctl,
  input logic         violPulse,
  input logic [N-1:0] shiftWord,
  input logic [N-1:0] latchWord,
  input logic [N-1:0] parOut,
  input logic         serOut,
  input logic         timingViol
);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |=> shiftWord[0] == $past(ctl.dataBit));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |=> shiftWord[N-1:1] == $past(shiftWord[N-2:0]));

  assert_serout_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |=> serOut == $past(shiftWord[N-2]));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchEn |=> $stable(latchWord));

  assert_latch_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchEn |=> latchWord == $past(shiftWord));

  assert_blank_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.blankOn |-> parOut == '0);

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (timingViol && !violClear) |=> timingViol);

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    (violClear && !violPulse) |=> !timingViol);

  assert_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |=> timingViol);

endmodule

bind latchedSerialDriver sldChecker #(.N(N)) chk_i (
  .clk(clk), .rstN(rstN), .violClear(violClear), .ctl(ctl),
  .violPulse(violPulse), .shiftWord(shiftWord), .latchWord(latchWord),
  .parOut(parOut), .serOut(serOut), .timingViol(timingViol)
);

// File: tb/latchedSerialDriver_tb.sv
`timescale 1ns/1ps
module latchedSerialDriver_tb_top;

  localparam int N = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0, shiftClk = 1'b0, strobeIn = 1'b0, blankIn = 1'b0;
  logic violClear = 1'b0;
  logic [N-1:0] parOut;
  logic serOut, timingViol;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  latchedSerialDriver #(.N(N)) dut_i (
    .clk(clk), .rstN(rstN), .serIn(serIn), .shiftClk(shiftClk),
    .strobeIn(strobeIn), .blankIn(blankIn), .violClear(violClear),
    .parOut(parOut), .serOut(serOut), .timingViol(timingViol)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 40-cycle shift period: data changes 10 cycles before rise, 30 after.
  task automatic shiftBit(input logic b);
    serIn = b;
    waitCyc(10);
    shiftClk = 1'b1;
    waitCyc(20);
    shiftClk = 1'b0;
    waitCyc(10);
  endtask

  task automatic pulseStrobe();
    waitCyc(20);
    strobeIn = 1'b1;
    waitCyc(20);
    strobeIn = 1'b0;
    waitCyc(10);
  endtask

  task automatic clearFlag();
    violClear = 1'b1;
    waitCyc(1);
    violClear = 1'b0;
    waitCyc(3);
  endtask

  logic [N-1:0] prevWord = '0;
  logic [N-1:0] heldWord = '0;

  task automatic loadAndCheck(input logic [N-1:0] w);
    for (int j = 0; j < N; j++) begin
      shiftBit(w[N-1-j]);
      if (j + 1 < N)
        check(serOut == prevWord[N-2-j], "R4 cascade", 32'(serOut), 32'(prevWord[N-2-j]));
      else
        check(serOut == w[N-1], "R4 last stage", 32'(serOut), 32'(w[N-1]));
    end
    check(parOut == heldWord, "R5 hold while strobe low", 32'(parOut), 32'(heldWord));
    pulseStrobe();
    check(parOut == w, "R3 parallel word", 32'(parOut), 32'(w));
    heldWord = w;
    prevWord = w;
    blankIn = 1'b1;
    waitCyc(10);
    check(parOut == '0, "R7 blank forces zero", 32'(parOut), 32'h0);
    blankIn = 1'b0;
    waitCyc(10);
    check(parOut == w, "R8 latch kept through blank", 32'(parOut), 32'(w));
  endtask

  initial begin : main
    logic [N-1:0] w;
    logic [N-1:0] v;
    waitCyc(5);
    check(parOut == '0, "R1 reset parOut", 32'(parOut), 32'h0);
    check(serOut == 1'b0, "R1 reset serOut", 32'(serOut), 32'h0);
    check(timingViol == 1'b0, "R1 reset flag", 32'(timingViol), 32'h0);
    rstN = 1'b1;
    waitCyc(50);

    loadAndCheck('0);
    loadAndCheck('1);
    for (int i = 0; i < N; i++) w[i] = i[0];
    loadAndCheck(w);
    loadAndCheck(~w);
    for (int i = 0; i < N; i++) loadAndCheck(N'(1) << i);
    for (int i = 0; i < N; i += 3) loadAndCheck(~(N'(1) << i));
    check(timingViol == 1'b0, "R13 no flag on conforming stimulus", 32'(timingViol), 32'h0);

    // Transparent latches: strobe held high, parOut tracks each shift.
    v = prevWord;
    waitCyc(20);
    strobeIn = 1'b1;
    waitCyc(20);
    for (int j = 0; j < 6; j++) begin
      shiftBit(j[1] ^ j[0]);
      v = {v[N-2:0], logic'(j[1] ^ j[0])};
      check(parOut[0] == logic'(j[1] ^ j[0]), "R2 stage one capture",
            32'(parOut[0]), 32'(j[1] ^ j[0]));
      check(parOut == v, "R6 transparent follow", 32'(parOut), 32'(v));
    end
    blankIn = 1'b1;
    shiftBit(1'b1);
    v = {v[N-2:0], 1'b1};
    check(parOut == '0, "R7 blank during bypass entry", 32'(parOut), 32'h0);
    blankIn = 1'b0;
    waitCyc(10);
    check(parOut == v, "R6 shown after blank release", 32'(parOut), 32'(v));
    waitCyc(20);
    strobeIn = 1'b0;
    waitCyc(40);
    check(timingViol == 1'b0, "R13 no flag after bypass", 32'(timingViol), 32'h0);

    // Setup breach: data change 3 cycles before rise.
    serIn = ~serIn;
    waitCyc(3);
    shiftClk = 1'b1;
    waitCyc(20);
    shiftClk = 1'b0;
    waitCyc(30);
    check(timingViol == 1'b1, "R9 setup breach", 32'(timingViol), 32'h1);
    waitCyc(100);
    check(timingViol == 1'b1, "R12 flag sticky", 32'(timingViol), 32'h1);
    clearFlag();
    check(timingViol == 1'b0, "R12 flag cleared", 32'(timingViol), 32'h0);

    // Hold breach: data change 3 cycles after rise.
    waitCyc(30);
    shiftClk = 1'b1;
    waitCyc(3);
    serIn = ~serIn;
    waitCyc(17);
    shiftClk = 1'b0;
    waitCyc(30);
    check(timingViol == 1'b1, "R9 hold breach", 32'(timingViol), 32'h1);
    clearFlag();

    // Short data pulse.
    waitCyc(40);
    serIn = ~serIn;
    waitCyc(5);
    serIn = ~serIn;
    waitCyc(40);
    check(timingViol == 1'b1, "R10 data width breach", 32'(timingViol), 32'h1);
    clearFlag();

    // Short clock pulse.
    waitCyc(40);
    shiftClk = 1'b1;
    waitCyc(5);
    shiftClk = 1'b0;
    waitCyc(40);
    check(timingViol == 1'b1, "R10 clock width breach", 32'(timingViol), 32'h1);
    clearFlag();

    // Short strobe pulse.
    waitCyc(60);
    check(timingViol == 1'b0, "R12 idle after clear", 32'(timingViol), 32'h0);
    strobeIn = 1'b1;
    waitCyc(4);
    strobeIn = 1'b0;
    waitCyc(40);
    check(timingViol == 1'b1, "R10 strobe width breach", 32'(timingViol), 32'h1);
    clearFlag();

    // Strobe too soon after a clock rise.
    waitCyc(60);
    shiftClk = 1'b1;
    waitCyc(10);
    strobeIn = 1'b1;
    waitCyc(10);
    shiftClk = 1'b0;
    waitCyc(10);
    strobeIn = 1'b0;
    waitCyc(30);
    check(timingViol == 1'b1, "R11 clock to strobe breach", 32'(timingViol), 32'h1);
    clearFlag();
    check(timingViol == 1'b0, "R12 final clear", 32'(timingViol), 32'h0);

    rstN = 1'b0;
    waitCyc(2);
    check(parOut == '0 && serOut == 1'b0, "R1 reset again", 32'(parOut), 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule